// File: doc/BRIEF.md
# Per-Circuit Cell Dispatcher with AAL5 Reassembly Check

The block sits in a chain of cell-handling stages. Each ATM cell arrives as thirteen 32-bit beats: one header beat followed by twelve payload beats. From the header it takes the virtual circuit index and looks it up in a small local table. The table entry decides what happens to the cell. The cell can pass along the chain unchanged. It can be diverted into the memory of an attached processor. It can also be sent both ways. A lookup miss always means pass-along.

For diverted circuits the block writes the payload words to consecutive addresses, starting at the circuit's running write pointer. As the words go by, it accumulates the AAL5 CRC for that circuit. At the end of a packet it judges the residue:
- A good packet leaves a descriptor (start address and length in words) in that circuit's receive queue. The circuit is also added once to a service list.
- A bad packet is dropped quietly. The write pointer winds back so the space is reused.

The attached processor never gets an interrupt. It polls the pending bits and the service list, then pops descriptors. Memory writes leave through a write-request stream, grouped into batches of cells.

All three data streams use valid/ready handshakes:
- A beat moves when valid and ready are both high at a rising edge.
- A producer that raises valid holds its data stable until ready is seen.
- The input ready may depend on the header beat's content only through its requirement for a chain-output slot. It never depends on input valid.

The processor and configuration pins are plain single-cycle strobes. The parameters NVC and RXQ_DEPTH must be powers of two.

Top module: `vc_cell_steer`

## Requirements
- R1: The circuit index is header bits [19:4]. A table entry holds a valid bit, an action code and a write pointer. The action codes are 0 pass-along, 1 divert and 2 both; code 3 behaves as pass-along. An index of NVC or more, or an entry whose valid bit is clear, is a miss and is passed along.
- R2: A passed-along cell leaves the chain output as all thirteen beats, unchanged and in order. Nothing goes to memory.
- R3: A diverted cell writes its twelve payload words, and not its header, to consecutive addresses starting at the circuit's write pointer. The pointer then advances by twelve. Nothing appears on the chain output.
- R4: A cell whose action is "both" appears in full on the chain output and also has its payload written to memory as in R3.
- R5: A packet ends with the cell whose header bit 1 is set. The CRC is CRC-32 with generator 0x04C11DB7 and preset all ones, taken MSB first over every payload word of the packet. The last word of the packet carries the inverted CRC of the words before it. When the final residue is 0xC704DD7B, a descriptor holding the packet's start address and its length in words is appended to that circuit's receive queue. It is visible one cycle after the last word is accepted, provided the queue has space.
- R6: A packet whose residue is wrong gives no descriptor and no service-list entry. The circuit's write pointer returns to the packet's start address.
- R7: A good packet adds its circuit to the tail of the service list only if that circuit is not already on the list. A svc_pop removes the head entry.
- R8: Suppose svc_pop removes a circuit in the same cycle as a good packet on that same circuit completes. The circuit is then appended again, and the list ends holding it once.
- R9: Diverted words are held back until a group is released. A group is released when BATCH diverted cells have accumulated or a packet ends. mem_last is high only on the word that releases a group.
- R10: While a stream's ready is low, its valid and data hold stable. in_ready falls whenever the chain output or the memory path that the current beat needs cannot take it.
- R11: After reset:
  - out_valid, mem_valid, svc_valid and rx_pending are all low;
  - in_ready is high;
  - every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_vc | input | $clog2(NVC) | Table entry to write |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_action | input | 2 | Action code (0 pass, 1 divert, 2 both) |
| cfg_ptr | input | ADDR_W | Initial write pointer; also restarts CRC and packet start |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 32 | Input beat: header, then twelve payload words |
| out_valid | output | 1 | Chain output beat valid |
| out_ready | input | 1 | Next stage can accept |
| out_data | output | 32 | Chain output beat |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write word address |
| mem_data | output | 32 | Write data |
| mem_last | output | 1 | Last word of a released batch |
| svc_valid | output | 1 | Service list not empty |
| svc_vc | output | $clog2(NVC) | Circuit at the head of the service list |
| svc_pop | input | 1 | Remove the head of the service list |
| rxq_sel | input | $clog2(NVC) | Receive queue selected for reading |
| rxq_pop | input | 1 | Remove the head descriptor of the selected queue |
| rxq_valid | output | 1 | Selected queue holds a descriptor |
| rxq_ptr | output | ADDR_W | Start address of the head descriptor |
| rxq_len | output | ADDR_W | Length in words of the head descriptor |
| rx_pending | output | NVC | Per-circuit receive-queue-not-empty bits |

## Verification
Two things can land in the same cycle: the processor popping a circuit off the service list, and a good packet on that very circuit completing. The bench provokes this by raising svc_pop in the same cycle as the last payload beat of a second packet on a circuit that is already listed. It then judges the result by reading the list: the circuit must still be present exactly once, and one more pop must empty the list. A second overlap is also exercised: a cell marked "both" needs the chain output and the memory path in the same beat. The bench holds one of those paths back and checks that the cell waits as a whole on both sides.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  typedef enum logic [1:0] {
    ACT_FWD   = 2'd0,
    ACT_LOCAL = 2'd1,
    ACT_BOTH  = 2'd2,
    ACT_RSVD  = 2'd3
  } vc_action_e;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_GOOD = 32'hC704_DD7B;

  // one 32-bit word folded into the running CRC, most significant bit first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction
endpackage

// File: rtl/vcd_vc_table.sv
module vcd_vc_table
  import vcd_pkg::*;
#(
  parameter int NVC    = 4,
  parameter int VC_W   = 16,
  parameter int ADDR_W = 12,
  localparam int IW    = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_vc,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_action,
  input  logic [ADDR_W-1:0] cfg_ptr,
  input  logic [VC_W-1:0]   lk_vci,
  output vc_action_e        lk_act,
  output logic [IW-1:0]     lk_idx,
  input  logic              upd_en,
  input  logic              upd_last,
  input  logic [IW-1:0]     upd_idx,
  input  logic [31:0]       upd_data,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              done_good,
  output logic [ADDR_W-1:0] done_start,
  output logic [ADDR_W-1:0] done_len
);
  logic              ent_valid [NVC];
  vc_action_e        ent_act   [NVC];
  logic [ADDR_W-1:0] wptr_q    [NVC];
  logic [ADDR_W-1:0] sptr_q    [NVC];
  logic [31:0]       crc_q     [NVC];

  logic [31:0] crc_nxt;
  logic        in_range;
  vc_action_e  raw_act;

  assign lk_idx   = lk_vci[IW-1:0];
  assign in_range = int'(lk_vci) < NVC;
  assign raw_act  = ent_act[lk_idx];

  always_comb begin
    if (in_range && ent_valid[lk_idx] && (raw_act == ACT_LOCAL || raw_act == ACT_BOTH))
      lk_act = raw_act;
    else
      lk_act = ACT_FWD;
  end

  assign cur_ptr    = wptr_q[upd_idx];
  assign crc_nxt    = crc32_step(crc_q[upd_idx], upd_data);
  assign done_good  = upd_en && upd_last && (crc_nxt == CRC_GOOD);
  assign done_start = sptr_q[upd_idx];
  assign done_len   = cur_ptr - sptr_q[upd_idx] + ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVC; i++) begin
        ent_valid[i] <= 1'b0;
        ent_act[i]   <= ACT_FWD;
        wptr_q[i]    <= '0;
        sptr_q[i]    <= '0;
        crc_q[i]     <= CRC_INIT;
      end
    end else begin
      if (upd_en) begin
        if (upd_last) begin
          crc_q[upd_idx] <= CRC_INIT;
          if (crc_nxt == CRC_GOOD) begin
            wptr_q[upd_idx] <= cur_ptr + ADDR_W'(1);
            sptr_q[upd_idx] <= cur_ptr + ADDR_W'(1);
          end else begin
            wptr_q[upd_idx] <= sptr_q[upd_idx];  // rewind over the dropped packet
          end
        end else begin
          crc_q[upd_idx]  <= crc_nxt;
          wptr_q[upd_idx] <= cur_ptr + ADDR_W'(1);
        end
      end
      if (cfg_we) begin
        ent_valid[cfg_vc] <= cfg_valid;
        ent_act[cfg_vc]   <= vc_action_e'(cfg_action);
        wptr_q[cfg_vc]    <= cfg_ptr;
        sptr_q[cfg_vc]    <= cfg_ptr;
        crc_q[cfg_vc]     <= CRC_INIT;
      end
    end
  end
endmodule

// File: rtl/vcd_batch_fifo.sv
module vcd_batch_fifo #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 24,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [31:0]       push_data,
  input  logic              push_release,
  output logic              full,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              mem_last
);
  logic [ADDR_W-1:0] addr_m [DEPTH];
  logic [31:0]       data_m [DEPTH];
  logic              last_m [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q, avail_q, unrel_q;
  logic              pop;

  assign full      = cnt_q == CW'(DEPTH);
  assign mem_valid = avail_q != '0;
  assign pop       = mem_valid && mem_ready;
  assign mem_addr  = addr_m[rd_q];
  assign mem_data  = data_m[rd_q];
  assign mem_last  = last_m[rd_q];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_m[wr_q] <= push_addr;
      data_m[wr_q] <= push_data;
      last_m[wr_q] <= push_release;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      avail_q <= '0;
      unrel_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      if (push && push_release) begin
        avail_q <= avail_q - CW'(pop) + unrel_q + CW'(1);
        unrel_q <= '0;
      end else begin
        avail_q <= avail_q - CW'(pop);
        if (push) unrel_q <= unrel_q + CW'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full)); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R10
endmodule

// File: rtl/vcd_service_list.sv
module vcd_service_list #(
  parameter int NVC = 4,
  localparam int IW = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int CW = $clog2(NVC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          append_en,
  input  logic [IW-1:0] append_idx,
  input  logic          pop,
  output logic          svc_valid,
  output logic [IW-1:0] svc_idx
);
  logic [IW-1:0]  q_m [NVC];
  logic [NVC-1:0] on_list_q;
  logic [IW-1:0]  wr_q, rd_q;
  logic [CW-1:0]  cnt_q;
  logic           do_pop, do_app;

  assign svc_valid = cnt_q != '0;
  assign svc_idx   = q_m[rd_q];
  assign do_pop    = pop && svc_valid;
  assign do_app    = append_en &&
                     (!on_list_q[append_idx] || (do_pop && svc_idx == append_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVC; i++) q_m[i] <= '0;
      on_list_q <= '0;
      wr_q      <= '0;
      rd_q      <= '0;
      cnt_q     <= '0;
    end else begin
      if (do_pop) begin
        on_list_q[svc_idx] <= 1'b0;
        rd_q <= rd_q + IW'(1);
      end
      if (do_app) begin
        on_list_q[append_idx] <= 1'b1;  // set wins over a same-cycle clear
        q_m[wr_q] <= append_idx;
        wr_q <= wr_q + IW'(1);
      end
      cnt_q <= cnt_q + CW'(do_app) - CW'(do_pop);
    end
  end

  AST_SVC_DEDUP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(on_list_q) == int'(cnt_q)); // R7

  AST_SVC_REPOP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && append_en && svc_idx == append_idx) |=> on_list_q[$past(append_idx)]); // R8
endmodule

// File: rtl/vcd_rx_queues.sv
module vcd_rx_queues #(
  parameter int NVC    = 4,
  parameter int QD     = 4,
  parameter int ADDR_W = 12,
  localparam int IW    = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int QW    = (QD > 1) ? $clog2(QD) : 1,
  localparam int CW    = $clog2(QD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [IW-1:0]     push_idx,
  input  logic [ADDR_W-1:0] push_ptr,
  input  logic [ADDR_W-1:0] push_len,
  output logic              push_space,
  input  logic [IW-1:0]     sel,
  input  logic              pop,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_ptr,
  output logic [ADDR_W-1:0] q_len,
  output logic [NVC-1:0]    pending
);
  logic [ADDR_W-1:0] ptr_m [NVC*QD];
  logic [ADDR_W-1:0] len_m [NVC*QD];
  logic [QW-1:0]     wr_q [NVC];
  logic [QW-1:0]     rd_q [NVC];
  logic [CW-1:0]     cnt_q [NVC];
  logic              do_push, do_pop;

  assign push_space = cnt_q[push_idx] != CW'(QD);
  assign do_push    = push_en && push_space;
  assign q_valid    = cnt_q[sel] != '0;
  assign do_pop     = pop && q_valid;
  assign q_ptr      = ptr_m[{sel, rd_q[sel]}];
  assign q_len      = len_m[{sel, rd_q[sel]}];

  for (genvar g = 0; g < NVC; g++) begin : g_pend
    assign pending[g] = cnt_q[g] != '0;
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      ptr_m[{push_idx, wr_q[push_idx]}] <= push_ptr;
      len_m[{push_idx, wr_q[push_idx]}] <= push_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVC; i++) begin
        wr_q[i]  <= '0;
        rd_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NVC; i++) begin
        if (do_push && push_idx == IW'(i)) wr_q[i] <= wr_q[i] + QW'(1);
        if (do_pop && sel == IW'(i))       rd_q[i] <= rd_q[i] + QW'(1);
        cnt_q[i] <= cnt_q[i] + CW'(do_push && push_idx == IW'(i))
                             - CW'(do_pop && sel == IW'(i));
      end
    end
  end

  AST_RXQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> pending[$past(push_idx)]); // R5
endmodule

// File: rtl/vc_cell_steer.sv
module vc_cell_steer
  import vcd_pkg::*;
#(
  parameter int NVC       = 4,
  parameter int VC_W      = 16,
  parameter int ADDR_W    = 12,
  parameter int PAY_WORDS = 12,
  parameter int BATCH     = 2,
  parameter int RXQ_DEPTH = 4,
  localparam int IW       = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int BW       = $clog2(PAY_WORDS + 1),
  localparam int KW       = $clog2(BATCH + 1),
  localparam int FDEPTH   = BATCH * PAY_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_vc,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_action,
  input  logic [ADDR_W-1:0] cfg_ptr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              mem_last,
  output logic              svc_valid,
  output logic [IW-1:0]     svc_vc,
  input  logic              svc_pop,
  input  logic [IW-1:0]     rxq_sel,
  input  logic              rxq_pop,
  output logic              rxq_valid,
  output logic [ADDR_W-1:0] rxq_ptr,
  output logic [ADDR_W-1:0] rxq_len,
  output logic [NVC-1:0]    rx_pending
);
  logic [BW-1:0]  beat_q;
  vc_action_e     cell_act_q;
  logic [IW-1:0]  cell_idx_q;
  logic           cell_eop_q;
  logic           out_valid_q;
  logic [31:0]    out_data_q;
  logic [KW-1:0]  batch_q;

  vc_action_e        lk_act;
  logic [IW-1:0]     lk_idx;
  logic [ADDR_W-1:0] cur_ptr, done_start, done_len;
  logic              done_good, fifo_full, q_space;
  logic              is_hdr, last_beat, out_free, cell_fwd, cell_loc;
  logic              accept, fwd_now, push_loc, release_now;

  assign is_hdr    = beat_q == '0;
  assign last_beat = beat_q == BW'(PAY_WORDS);
  assign out_free  = !out_valid_q || out_ready;
  assign cell_fwd  = cell_act_q != ACT_LOCAL;
  assign cell_loc  = cell_act_q == ACT_LOCAL || cell_act_q == ACT_BOTH;

  // header beats always wait for a chain slot; payload beats wait only on the paths they use
  assign in_ready = is_hdr ? out_free
                           : ((!cell_fwd || out_free) && (!cell_loc || !fifo_full));
  assign accept   = in_valid && in_ready;
  assign fwd_now  = is_hdr ? (lk_act != ACT_LOCAL) : cell_fwd;
  assign push_loc = accept && !is_hdr && cell_loc;
  assign release_now = last_beat && (cell_eop_q || batch_q == KW'(BATCH - 1));

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  vcd_vc_table #(.NVC(NVC), .VC_W(VC_W), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_vc(cfg_vc), .cfg_valid(cfg_valid),
    .cfg_action(cfg_action), .cfg_ptr(cfg_ptr),
    .lk_vci(in_data[4 +: VC_W]), .lk_act(lk_act), .lk_idx(lk_idx),
    .upd_en(push_loc), .upd_last(last_beat && cell_eop_q), .upd_idx(cell_idx_q),
    .upd_data(in_data), .cur_ptr(cur_ptr),
    .done_good(done_good), .done_start(done_start), .done_len(done_len)
  );

  vcd_batch_fifo #(.ADDR_W(ADDR_W), .DEPTH(FDEPTH)) u_batch (
    .clk(clk), .rst_n(rst_n),
    .push(push_loc), .push_addr(cur_ptr), .push_data(in_data),
    .push_release(release_now), .full(fifo_full),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_last(mem_last)
  );

  vcd_service_list #(.NVC(NVC)) u_svc (
    .clk(clk), .rst_n(rst_n),
    .append_en(done_good && q_space), .append_idx(cell_idx_q),
    .pop(svc_pop), .svc_valid(svc_valid), .svc_idx(svc_vc)
  );

  vcd_rx_queues #(.NVC(NVC), .QD(RXQ_DEPTH), .ADDR_W(ADDR_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_en(done_good), .push_idx(cell_idx_q),
    .push_ptr(done_start), .push_len(done_len), .push_space(q_space),
    .sel(rxq_sel), .pop(rxq_pop),
    .q_valid(rxq_valid), .q_ptr(rxq_ptr), .q_len(rxq_len),
    .pending(rx_pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q      <= '0;
      cell_act_q  <= ACT_FWD;
      cell_idx_q  <= '0;
      cell_eop_q  <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      batch_q     <= '0;
    end else begin
      if (accept) begin
        if (is_hdr) begin
          cell_act_q <= lk_act;
          cell_idx_q <= lk_idx;
          cell_eop_q <= in_data[1];
          beat_q     <= BW'(1);
        end else if (last_beat) begin
          beat_q <= '0;
        end else begin
          beat_q <= beat_q + BW'(1);
        end
      end
      if (accept && fwd_now) begin
        out_valid_q <= 1'b1;
        out_data_q  <= in_data;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
      if (push_loc && last_beat)
        batch_q <= release_now ? '0 : batch_q + KW'(1);
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  AST_NO_CHAIN_FOR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_hdr && cell_act_q == ACT_LOCAL && !out_valid) |=> !out_valid); // R3
endmodule

// File: tb/tb_vc_cell_steer.sv
module tb_vc_cell_steer;
  localparam int NVC = 4;
  localparam int AW  = 12;
  localparam int PW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cfg_we = 0, cfg_valid = 0;
  logic [1:0]    cfg_vc = 0;
  logic [1:0]    cfg_action = 0;
  logic [AW-1:0] cfg_ptr = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [31:0]   in_data = 0;
  logic          out_valid, out_ready = 1;
  logic [31:0]   out_data;
  logic          mem_valid, mem_ready = 1, mem_last;
  logic [AW-1:0] mem_addr, rxq_ptr, rxq_len;
  logic [31:0]   mem_data;
  logic          svc_valid, svc_pop = 0, rxq_pop = 0, rxq_valid;
  logic [1:0]    svc_vc, rxq_sel = 0;
  logic [NVC-1:0] rx_pending;

  vc_cell_steer dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_vc(cfg_vc), .cfg_valid(cfg_valid),
    .cfg_action(cfg_action), .cfg_ptr(cfg_ptr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_last(mem_last),
    .svc_valid(svc_valid), .svc_vc(svc_vc), .svc_pop(svc_pop),
    .rxq_sel(rxq_sel), .rxq_pop(rxq_pop), .rxq_valid(rxq_valid),
    .rxq_ptr(rxq_ptr), .rxq_len(rxq_len), .rx_pending(rx_pending)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0]   out_log [64];
  int            out_cnt = 0;
  logic [AW-1:0] mem_alog [128];
  logic [31:0]   mem_dlog [128];
  logic          mem_llog [128];
  int            mem_cnt = 0;
  logic [31:0]   pkt [48];
  logic [AW-1:0] vc0_ptr = 12'h100;
  logic [AW-1:0] vc1_ptr = 12'h200;

  always @(negedge clk) begin
    if (out_valid && out_ready && out_cnt < 64) begin
      out_log[out_cnt] = out_data;
      out_cnt++;
    end
    if (mem_valid && mem_ready && mem_cnt < 128) begin
      mem_alog[mem_cnt] = mem_addr;
      mem_dlog[mem_cnt] = mem_data;
      mem_llog[mem_cnt] = mem_last;
      mem_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] != d[b]) r = (r << 1) ^ 32'h04C11DB7;
      else               r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] hdr(input logic [15:0] vci, input logic eop);
    return {12'h0, vci, 2'b00, eop, 1'b0};
  endfunction

  task automatic make_pkt(input int ncells, input int seed, input bit bad);
    logic [31:0] c = 32'hFFFF_FFFF;
    int n = ncells * PW;
    for (int i = 0; i < n - 1; i++) begin
      pkt[i] = (seed * 32'h0100_0193) ^ (i * 32'h9E37_79B9);
      c = ref_crc(c, pkt[i]);
    end
    pkt[n-1] = ~c ^ (bad ? 32'h0000_0010 : 32'h0);
  endtask

  task automatic beat(input logic [31:0] d, input bit pop_here);
    in_valid = 1'b1;
    in_data  = d;
    svc_pop  = pop_here;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
    svc_pop  = 1'b0;
  endtask

  task automatic send_cell(input logic [15:0] vci, input int c, input bit eop, input bit pop_last);
    beat(hdr(vci, eop), 1'b0);
    for (int k = 0; k < PW; k++) beat(pkt[c*PW + k], pop_last && eop && k == PW - 1);
  endtask

  task automatic send_pkt(input logic [15:0] vci, input int ncells, input bit pop_last);
    for (int c = 0; c < ncells; c++) send_cell(vci, c, c == ncells - 1, pop_last);
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
    #2;
  endtask

  task automatic clear_logs();
    out_cnt = 0;
    mem_cnt = 0;
  endtask

  task automatic configure(input logic [1:0] vc, input bit v, input logic [1:0] act, input logic [AW-1:0] p);
    cfg_we = 1; cfg_vc = vc; cfg_valid = v; cfg_action = act; cfg_ptr = p;
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic pop_svc();
    svc_pop = 1; @(posedge clk); #2; svc_pop = 0;
  endtask

  task automatic pop_rx(input logic [1:0] vc);
    rxq_sel = vc; rxq_pop = 1; @(posedge clk); #2; rxq_pop = 0;
  endtask

  task automatic check_mem_pkt(input string req, input logic [AW-1:0] base, input int n);
    check(mem_cnt == n, req, "mem word count", mem_cnt, n);
    for (int i = 0; i < n && i < mem_cnt; i++) begin
      if (mem_alog[i] != base + AW'(i) || mem_dlog[i] != pkt[i])
        check(0, req, "mem word", {20'h0, mem_alog[i]}, {20'h0, base + AW'(i)});
    end
    check(mem_cnt > 0 && mem_dlog[0] == pkt[0], req, "first mem data", mem_dlog[0], pkt[0]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0 && mem_valid == 0, "R11", "ready/valids",
          {29'h0, in_ready, out_valid, mem_valid}, 32'h4);
    check(svc_valid == 0 && rx_pending == 0, "R11", "svc/pending",
          {27'h0, svc_valid, rx_pending}, 32'h0);
  endtask

  task automatic t_forward();
    logic [15:0] vcis [3] = '{16'd9, 16'd3, 16'd2};
    for (int v = 0; v < 3; v++) begin
      clear_logs();
      make_pkt(1, 10 + v, 0);
      send_cell(vcis[v], 0, 1'b1, 1'b0);
      settle();
      check(out_cnt == 13, "R1", "forwarded beat count", out_cnt, 13);
      check(out_log[0] == hdr(vcis[v], 1'b1), "R2", "forwarded header", out_log[0], hdr(vcis[v], 1'b1));
      for (int k = 0; k < PW; k++)
        if (out_log[k+1] != pkt[k]) check(0, "R2", "forwarded payload", out_log[k+1], pkt[k]);
      check(mem_cnt == 0, "R2", "no memory writes on pass-along", mem_cnt, 0);
    end
  endtask

  task automatic t_local();
    clear_logs();
    make_pkt(1, 21, 0);
    send_cell(16'd0, 0, 1'b1, 1'b0);
    settle();
    check(out_cnt == 0, "R3", "nothing on chain", out_cnt, 0);
    check_mem_pkt("R3", vc0_ptr, PW);
    check(mem_llog[PW-1] == 1 && mem_llog[0] == 0, "R9", "last flag single cell",
          {30'h0, mem_llog[0], mem_llog[PW-1]}, 32'h1);
    check(svc_valid && svc_vc == 0, "R7", "service head", {30'h0, svc_vc}, 0);
    rxq_sel = 0; #1;
    check(rxq_valid && rxq_ptr == vc0_ptr && rxq_len == AW'(PW), "R5", "descriptor",
          {8'h0, rxq_ptr, rxq_len}, {8'h0, vc0_ptr, AW'(PW)});
    vc0_ptr = vc0_ptr + AW'(PW);
    pop_svc(); pop_rx(0);
    check(!svc_valid && rx_pending == 0, "R7", "list empty after pop",
          {27'h0, svc_valid, rx_pending}, 0);
  endtask

  task automatic t_both();
    clear_logs();
    make_pkt(1, 33, 0);
    send_cell(16'd1, 0, 1'b1, 1'b0);
    settle();
    check(out_cnt == 13 && out_log[0] == hdr(16'd1, 1'b1), "R4", "chain copy",
          out_cnt, 13);
    check_mem_pkt("R4", vc1_ptr, PW);
    check(svc_valid && svc_vc == 1 && rx_pending == 4'b0010, "R5", "both-mode completion",
          {27'h0, svc_valid, rx_pending}, 32'h12);
    vc1_ptr = vc1_ptr + AW'(PW);
    pop_svc(); pop_rx(1);
  endtask

  task automatic t_bad_crc();
    clear_logs();
    make_pkt(2, 44, 1);
    send_pkt(16'd0, 2, 1'b0);
    settle();
    check(!svc_valid && rx_pending == 0, "R6", "bad packet silent",
          {27'h0, svc_valid, rx_pending}, 0);
    check(mem_cnt == 2*PW && mem_alog[0] == vc0_ptr, "R6", "bad packet words", mem_cnt, 2*PW);
    clear_logs();
    make_pkt(1, 45, 0);
    send_cell(16'd0, 0, 1'b1, 1'b0);
    settle();
    check(mem_cnt > 0 && mem_alog[0] == vc0_ptr, "R6", "pointer rewound",
          {20'h0, mem_alog[0]}, {20'h0, vc0_ptr});
    rxq_sel = 0; #1;
    check(rxq_valid && rxq_ptr == vc0_ptr, "R6", "good after bad", {20'h0, rxq_ptr}, {20'h0, vc0_ptr});
    vc0_ptr = vc0_ptr + AW'(PW);
    pop_svc(); pop_rx(0);
  endtask

  task automatic t_batch();
    clear_logs();
    make_pkt(3, 55, 0);
    send_cell(16'd0, 0, 1'b0, 1'b0);
    repeat (6) @(posedge clk); #2;
    check(mem_cnt == 0 && !mem_valid, "R9", "held until batch", mem_cnt, 0);
    send_cell(16'd0, 1, 1'b0, 1'b0);
    send_cell(16'd0, 2, 1'b1, 1'b0);
    settle();
    check_mem_pkt("R9", vc0_ptr, 3*PW);
    for (int i = 0; i < 3*PW; i++) begin
      bit exp_last = (i == 2*PW - 1) || (i == 3*PW - 1);
      if (mem_llog[i] != exp_last) check(0, "R9", "last flag position", i, exp_last);
    end
    rxq_sel = 0; #1;
    check(rxq_len == AW'(3*PW), "R5", "multi-cell length", {20'h0, rxq_len}, 3*PW);
    vc0_ptr = vc0_ptr + AW'(3*PW);
    pop_svc(); pop_rx(0);
  endtask

  task automatic t_dedup();
    make_pkt(1, 66, 0);
    send_cell(16'd0, 0, 1'b1, 1'b0);
    make_pkt(1, 67, 0);
    send_cell(16'd0, 0, 1'b1, 1'b0);
    settle();
    check(svc_valid && svc_vc == 0, "R7", "listed once head", {30'h0, svc_vc}, 0);
    pop_svc();
    check(!svc_valid, "R7", "no duplicate entry", svc_valid, 0);
    pop_rx(0);
    rxq_sel = 0; #1;
    check(rxq_valid && rxq_ptr == vc0_ptr + AW'(PW), "R5", "second descriptor queued",
          {20'h0, rxq_ptr}, {20'h0, vc0_ptr + AW'(PW)});
    pop_rx(0);
    check(rx_pending == 0, "R5", "queue drained", rx_pending, 0);
    vc0_ptr = vc0_ptr + AW'(2*PW);
  endtask

  task automatic t_same_cycle();
    make_pkt(1, 77, 0);
    send_cell(16'd1, 0, 1'b1, 1'b0);
    settle();
    check(svc_valid && svc_vc == 1, "R8", "listed before overlap", {31'h0, svc_valid}, 1);
    make_pkt(1, 78, 0);
    send_cell(16'd1, 0, 1'b1, 1'b1);
    settle();
    check(svc_valid && svc_vc == 1, "R8", "re-added after same-cycle pop",
          {29'h0, svc_valid, svc_vc}, 32'h5);
    pop_svc();
    check(!svc_valid, "R8", "held exactly once", svc_valid, 0);
    pop_rx(1); pop_rx(1);
    vc1_ptr = vc1_ptr + AW'(2*PW);
  endtask

  task automatic t_backpressure();
    clear_logs();
    make_pkt(1, 88, 0);
    out_ready = 0;
    fork
      send_cell(16'd1, 0, 1'b1, 1'b0);
      begin
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_data == hdr(16'd1, 1'b1), "R10", "chain held",
              out_data, hdr(16'd1, 1'b1));
        check(!in_ready && mem_cnt == 0, "R10", "input stalled", {31'h0, in_ready}, 0);
        @(posedge clk); #2;
        out_ready = 1;
      end
    join
    settle();
    check(out_cnt == 13 && out_log[0] == hdr(16'd1, 1'b1) && out_log[13-1] == pkt[PW-1],
          "R10", "stalled cell intact", out_cnt, 13);
    check_mem_pkt("R10", vc1_ptr, PW);
    vc1_ptr = vc1_ptr + AW'(PW);
    pop_svc(); pop_rx(1);

    clear_logs();
    mem_ready = 0;
    make_pkt(1, 89, 0);
    send_cell(16'd0, 0, 1'b1, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(mem_valid && mem_addr == vc0_ptr && mem_data == pkt[0], "R10", "mem held",
          {20'h0, mem_addr}, {20'h0, vc0_ptr});
    @(posedge clk); #2;
    mem_ready = 1;
    settle();
    check_mem_pkt("R10", vc0_ptr, PW);
    vc0_ptr = vc0_ptr + AW'(PW);
    pop_svc(); pop_rx(0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    configure(2'd0, 1, 2'd1, 12'h100);
    configure(2'd1, 1, 2'd2, 12'h200);
    configure(2'd2, 1, 2'd0, 12'h300);
    configure(2'd3, 0, 2'd1, 12'h380);
    t_forward();
    t_local();
    t_both();
    t_bad_crc();
    t_batch();
    t_dedup();
    t_same_cycle();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule